// File: doc/BRIEF.md
# Command-Driven Interval Timer Channel

This block is a single up-counting timer channel. Software controls it through a small register window that is addressed in words. Three offsets act as command strobes: a write to one of them restarts the count, starts the timer or stops it. The data carried by such a write is discarded. The other offsets hold:

- a mode bit that selects continuous or one-shot operation;
- a terminal count, which can be written and read back;
- an interrupt enable;
- an interrupt acknowledge;
- a read-only live count;
- a read-only status word.

The counter advances once for each clock cycle in which `tick_en` is high and the timer is running. When it matches the terminal count, it raises a pending flag. In continuous mode it then starts again from zero. In one-shot mode it parks and the timer stops. The `irq` output is a level: it is high while the pending flag and the interrupt enable are both set. With the terminal count at all ones in continuous mode, the channel is a free-running wrapping counter that suits a time base.

The bus port is a plain single-cycle strobe. `bus_valid` with `bus_write` high performs a write on the next clock edge. `bus_valid` with `bus_write` low returns read data on `bus_rdata` in the same cycle, through combinational logic.

Top module: `cmd_interval_timer`

## Requirements
- R1: Register offsets are used only when `bus_addr[1:0]` is 0. They are: 0x00 restart, 0x04 start, 0x08 stop, 0x0C mode, 0x10 status, 0x14 live count, 0x18 terminal count, 0x1C interrupt enable, 0x20 acknowledge.
- R2: A write of any data to 0x00, 0x04 or 0x08 performs that command. 0x04 sets the running state and 0x08 clears it.
- R3: The live count rises by one for each cycle in which the timer is running and `tick_en` is high. It holds in every other cycle.
- R4: Continuous mode is mode bit 0 = 0. When a tick arrives while the count equals the terminal count, the pending flag is set and the count returns to 0, so the period is terminal+1 ticks.
- R5: One-shot mode is mode bit 0 = 1. The same event sets the pending flag, clears the running state and leaves the count at the terminal value.
- R6: A restart command sets the count to 0 and clears the pending flag. It leaves the terminal count, the mode and the interrupt enable unchanged.
- R7: `irq` is high exactly while the pending flag and the interrupt enable are both set. The interrupt enable is taken from bit 0 of a write to 0x1C.
- R8: A write to 0x20 with bit 7 set clears the pending flag, and a write with bit 7 clear has no effect. If a terminal event happens in the same cycle, the flag stays set.
- R9: Reads of 0x00, 0x04, 0x08, 0x0C, 0x1C, 0x20, unmapped offsets and misaligned addresses return 0. Writes to 0x10 and 0x14 change nothing.
- R10: The status word reads as follows. Bits [3:0] hold the run code: 1 when stopped, 2 when running. Bit 4 is set while running. Bit 5 is the mode (1 = one-shot). Bit 6 is the interrupt enable. Bit 7 is the pending flag.
- R11: After hardware reset the count is 0, the terminal count is all ones, the mode is continuous, and the timer is stopped, with no interrupt enabled or pending. The status reads 0x01.
- R12: With the terminal count all ones in continuous mode, the count wraps from its maximum to 0 and raises the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-advance qualifier |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the channel window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of a read |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the channel with an 8-bit counter (CNT_W = 8) and the default 6-bit address and 32-bit data widths. The narrow counter makes the all-ones terminal count reachable in 256 ticks, so the free-running wrap and its pending event are tested directly rather than inferred. Small terminal values give short periods in both modes. They also set up the case where an acknowledge lands in the same cycle as a terminal event.

// File: rtl/cmd_interval_timer.sv
module cmd_interval_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] W_RESTART = IW'(0);
  localparam logic [IW-1:0] W_START   = IW'(1);
  localparam logic [IW-1:0] W_STOP    = IW'(2);
  localparam logic [IW-1:0] W_MODE    = IW'(3);
  localparam logic [IW-1:0] W_STATUS  = IW'(4);
  localparam logic [IW-1:0] W_COUNT   = IW'(5);
  localparam logic [IW-1:0] W_TERM    = IW'(6);
  localparam logic [IW-1:0] W_IEN     = IW'(7);
  localparam logic [IW-1:0] W_ACK     = IW'(8);
  localparam logic [3:0]    RUN_IDLE  = 4'd1;
  localparam logic [3:0]    RUN_BUSY  = 4'd2;

  logic [CNT_W-1:0] count, term;
  logic             running, one_shot, ien, pend;
  logic             aligned, wr, rd;
  logic [IW-1:0]    widx;
  logic             c_restart, c_start, c_stop, c_mode, c_term, c_ien, c_ack;
  logic             advance, hit, evt;
  logic [7:0]       status;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign widx    = bus_addr[ADDR_W-1:2];
  assign wr      = bus_valid &  bus_write & aligned;
  assign rd      = bus_valid & ~bus_write & aligned;

  assign c_restart = wr && (widx == W_RESTART);
  assign c_start   = wr && (widx == W_START);
  assign c_stop    = wr && (widx == W_STOP);
  assign c_mode    = wr && (widx == W_MODE);
  assign c_term    = wr && (widx == W_TERM);
  assign c_ien     = wr && (widx == W_IEN);
  assign c_ack     = wr && (widx == W_ACK) && bus_wdata[7];

  assign advance = running && tick_en;
  assign hit     = (count == term);
  assign evt     = advance && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (c_restart) begin
      count <= '0;
    end else if (advance) begin
      if (!hit)          count <= count + 1'b1;
      else if (!one_shot) count <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend <= 1'b0;
    else if (c_restart) pend <= 1'b0;
    else if (evt)       pend <= 1'b1;
    else if (c_ack)     pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                running <= 1'b0;
    else if (c_stop)           running <= 1'b0;
    else if (c_start)          running <= 1'b1;
    else if (evt && one_shot)  running <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term     <= '1;
      one_shot <= 1'b0;
      ien      <= 1'b0;
    end else begin
      if (c_term) term     <= bus_wdata[CNT_W-1:0];
      if (c_mode) one_shot <= bus_wdata[0];
      if (c_ien)  ien      <= bus_wdata[0];
    end
  end

  assign status = {pend, ien, one_shot, running, running ? RUN_BUSY : RUN_IDLE};
  assign irq    = pend & ien;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (widx)
        W_STATUS: bus_rdata = DATA_W'(status);
        W_COUNT:  bus_rdata = DATA_W'(count);
        W_TERM:   bus_rdata = DATA_W'(term);
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    c_restart |=> (count == '0) && !pend); // R6
  AST_EVENT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !c_restart) |=> pend); // R8
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ack && !evt && !c_restart) |=> !pend); // R8
  AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && one_shot && !c_start && !c_restart) |=> !running && $stable(count)); // R5
  AST_CONT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !one_shot) |=> (count == '0)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !c_restart) |=> $stable(count)); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend && ien)); // R7

endmodule

// File: tb/cmd_interval_timer_bench.sv
module cmd_interval_timer_bench;
  localparam int CW = 8;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  cmd_interval_timer #(.CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) u_cmd_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2, K_IRQ = 2'd3;
  localparam int NV = 47;
  localparam logic [41:0] VEC [NV] = '{
    {K_RD, 8'h10, 32'h01},           // R11 status after reset
    {K_RD, 8'h18, 32'hFF},           // R11 terminal all ones
    {K_RD, 8'h14, 32'h00},           // R11 count zero
    {K_WR, 8'h18, 32'h03},
    {K_WR, 8'h1C, 32'h01},
    {K_WR, 8'h04, 32'hDEAD},         // R2 start with junk data
    {K_RD, 8'h10, 32'h52},           // R10 running, ie
    {K_TK, 8'h00, 32'd2},
    {K_RD, 8'h14, 32'h02},           // R3
    {K_TK, 8'h00, 32'd1},
    {K_RD, 8'h14, 32'h03},           // R3
    {K_TK, 8'h00, 32'd1},
    {K_RD, 8'h14, 32'h00},           // R4 restart at zero
    {K_RD, 8'h10, 32'hD2},           // R4 pending set
    {K_IRQ, 8'h00, 32'h1},           // R7
    {K_WR, 8'h20, 32'h7F},
    {K_RD, 8'h10, 32'hD2},           // R8 ack without bit 7
    {K_WR, 8'h20, 32'h80},
    {K_RD, 8'h10, 32'h52},           // R8 ack clears
    {K_IRQ, 8'h00, 32'h0},           // R7
    {K_WR, 8'h08, 32'h1234},         // R2 stop with junk data
    {K_TK, 8'h00, 32'd3},
    {K_RD, 8'h14, 32'h00},           // R3 held while stopped
    {K_RD, 8'h10, 32'h41},           // R10 idle code
    {K_WR, 8'h0C, 32'h01},
    {K_WR, 8'h04, 32'h00},
    {K_TK, 8'h00, 32'd3},
    {K_RD, 8'h10, 32'h72},           // R10 one-shot running
    {K_TK, 8'h00, 32'd1},
    {K_RD, 8'h14, 32'h03},           // R5 parked at terminal
    {K_RD, 8'h10, 32'hE1},           // R5 stopped, pending
    {K_TK, 8'h00, 32'd2},
    {K_RD, 8'h14, 32'h03},           // R5 stays parked
    {K_WR, 8'h00, 32'h55},           // restart command
    {K_RD, 8'h14, 32'h00},           // R6 count cleared
    {K_RD, 8'h10, 32'h61},           // R6 pending cleared, mode/ie kept
    {K_RD, 8'h18, 32'h03},           // R6 terminal kept
    {K_WR, 8'h14, 32'h77},
    {K_RD, 8'h14, 32'h00},           // R9 count not writable
    {K_WR, 8'h10, 32'hFF},
    {K_RD, 8'h10, 32'h61},           // R9 status not writable
    {K_RD, 8'h0C, 32'h00},           // R9
    {K_RD, 8'h1C, 32'h00},           // R9
    {K_RD, 8'h04, 32'h00},           // R9
    {K_RD, 8'h24, 32'h00},           // R9 unmapped
    {K_RD, 8'h1A, 32'h00},           // R1 misaligned read
    {K_RD, 8'h20, 32'h00}            // R9
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d, input logic tk);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [DW-1:0] exp);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a[AW-1:0];
    #1 check(req, bus_rdata, exp);
    bus_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 irq after reset", {31'b0, irq}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][41:40])
        K_WR:  wr(VEC[i][39:32], VEC[i][31:0], 1'b0);
        K_RD:  rd($sformatf("vector %0d", i), VEC[i][39:32], VEC[i][31:0]);
        K_TK:  ticks(int'(VEC[i][31:0]));
        default: begin
          @(negedge clk);
          check($sformatf("vector %0d irq", i), {31'b0, irq}, VEC[i][31:0]);
        end
      endcase
    end

    // R12 free-running wrap after hardware reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wr(8'h04, 32'h0, 1'b0);
    ticks(255);
    rd("R12 count at max", 8'h14, 32'hFF);
    ticks(1);
    rd("R12 wrapped to zero", 8'h14, 32'h00);
    rd("R12 pending on wrap", 8'h10, 32'h92);
    check("R7 irq gated by ie=0", {31'b0, irq}, 32'h0);

    // R8 event and acknowledge in the same cycle: event wins
    wr(8'h18, 32'h00, 1'b0);
    wr(8'h20, 32'h80, 1'b1);
    rd("R8 event beats ack", 8'h10, 32'h92);
    wr(8'h20, 32'h80, 1'b0);
    rd("R8 ack alone clears", 8'h10, 32'h12);

    // R7 enabling the interrupt exposes a pending event
    ticks(1);
    check("R7 irq low while disabled", {31'b0, irq}, 32'h0);
    wr(8'h1C, 32'h01, 1'b0);
    check("R7 irq follows ie", {31'b0, irq}, 32'h1);
    wr(8'h1D, 32'h00, 1'b0);
    check("R1 misaligned write ignored", {31'b0, irq}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule